// File: doc/BRIEF.md
# IDE Bus-Master DMA Channel Control

This block holds the control side of a two-channel bus-master IDE DMA unit. Each channel has a start/stop bit that drives a four-state transfer sequencer (idle, moving data, draining, finished). While a channel is moving data or draining, its drive interrupt is kept away from the host. When the sequencer reaches the finished state, the pending interrupt reaches the host in that same cycle. Host software can always see the unmasked drive interrupt lines in a shared control register. That register also holds the per-port enable bits, the per-port 16-bit mode bits and a legacy interrupt routing bit.

A diagnostic register carries a soft-reset bit. While this bit is set, both sequencers are held in idle. Host software sets the bit and then clears it to recover a confused sequencer. The soft reset leaves the control register alone. A drive-side ATA reset on a port clears only that port's 16-bit mode bit. Descriptor fetching, the memory bus and configuration-space decoding belong to neighbouring logic. Here they are reduced to a plain register write strobe, an address, write data and a combinational read-back. The transfer-end and drain-empty indications come in as plain pins.

Top module: `ide_bm_ctl`

## Requirements
- R1: While `rst_n` is low, every register clears, both sequencers return to idle (state code 0), and `host_irq` follows `drv_irq`.
- R2: Bit 0 of a channel's command register starts the channel. Channel 0's command register is at address 0x00 and channel 1's is at 0x08. An idle channel with this bit set and no soft reset moves to active (code 1) at the clock edge after the write has landed.
- R3: An active channel moves to draining (code 2) on a clock edge where `xfer_last` is high. A draining channel moves to done (code 3) on an edge where `drain_empty` is high. Done holds while the start bit stays set.
- R4: When the start bit is cleared, the channel returns to idle at the next edge, from any state.
- R5: While a channel is active or draining, its `host_irq` is low whatever `drv_irq` does. While it is idle or done, `host_irq` equals `drv_irq`.
- R6: A drive interrupt that was held off appears on `host_irq` in the first cycle in which the channel is in done.
- R7: Reading the control register at 0x40 returns the unmasked `drv_irq[0]` at bit 28 and `drv_irq[1]` at bit 30, whether or not the interrupt is held off.
- R8: Within the control register, bits 0 and 4 (port enables), bits 1 and 5 (port 16-bit modes) and bit 11 (legacy routing) are read/write. All other bits read 0, apart from the bits given in R7.
- R9: Bit 18 of the diagnostic register at 0x7C is the soft reset, and it reads back. While it is set, both channels are forced to idle. After it is cleared, a channel whose start bit is still set re-enters active at the next edge.
- R10: The soft reset does not change the enable, 16-bit mode or legacy bits.
- R11: `ata_rst[i]` high at a clock edge clears port i's 16-bit mode bit (bit 1 for port 0, bit 5 for port 1). It wins over a control-register write in the same cycle and leaves all other bits as written.
- R12: Reading a command register returns that channel's start bit at bit 0 and zeros elsewhere.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Byte address for write and read-back |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read-back of the register at `reg_addr` |
| drv_irq | input | 2 | Interrupt request from each channel's drive |
| xfer_last | input | 2 | Last data beat of the transfer, per channel |
| drain_empty | input | 2 | Channel's outstanding data has been flushed |
| ata_rst | input | 2 | ATA reset issued on a port |
| host_irq | output | 2 | Interrupt presented to the host after holdoff |
| chan_state | output | 4 | Sequencer code per channel, 2 bits each, channel 0 in the low bits |

## Verification
The holdoff is tested with the drive interrupt held high on both channels while only one channel runs. This shows that gating is per channel and not global. The same interrupt is watched through idle, active, draining and done, so a release one cycle late or a mask left on after done shows up on `host_irq`. The control register is written with all-ones, all-zeros, single-field and scattered patterns, which separates writable bits from read-only ones and from the raw-interrupt bits. Two sequences are compared against a stop issued from the active state: a soft reset set and then cleared with the start bit still on, and an ATA reset that collides with a register write.

// File: rtl/ide_bm_pkg.sv
package ide_bm_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACTIVE = 2'd1,
    ST_DRAIN  = 2'd2,
    ST_DONE   = 2'd3
  } bm_state_e;

  // register map defaults (byte addresses)
  localparam int unsigned CMD_BASE_DEF   = 'h00;
  localparam int unsigned CMD_STRIDE_DEF = 'h08;
  localparam int unsigned CTRL_ADDR_DEF  = 'h40;
  localparam int unsigned DIAG_ADDR_DEF  = 'h7C;

  // control register field placement (per port i: enable 4i, wide mode 4i+1)
  localparam int unsigned PORT_STRIDE  = 4;
  localparam int unsigned WIDE_OFS     = 1;
  localparam int unsigned LEGACY_BIT   = 11;
  localparam int unsigned RAWIRQ_BASE  = 28;
  localparam int unsigned RAWIRQ_STEP  = 2;
  localparam int unsigned SRST_BIT     = 18;

endpackage

// File: rtl/ide_bm_chan_fsm.sv
module ide_bm_chan_fsm
  import ide_bm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run_bit,
  input  logic       soft_rst,
  input  logic       xfer_last,
  input  logic       drain_empty,
  input  logic       drv_irq,
  output logic [1:0] state_o,
  output logic       host_irq_o
);

  bm_state_e st_q, st_d;
  logic      holdoff;

  always_comb begin
    st_d = st_q;
    if (soft_rst || !run_bit) begin
      st_d = ST_IDLE;
    end else begin
      unique case (st_q)
        ST_IDLE:   st_d = ST_ACTIVE;
        ST_ACTIVE: if (xfer_last)   st_d = ST_DRAIN;
        ST_DRAIN:  if (drain_empty) st_d = ST_DONE;
        ST_DONE:   st_d = ST_DONE;
        default:   st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  // interrupt is withheld for as long as any DMA activity remains
  assign holdoff    = (st_q == ST_ACTIVE) || (st_q == ST_DRAIN);
  assign host_irq_o = drv_irq && !holdoff;
  assign state_o    = st_q;

  p_stop_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !run_bit |=> (state_o == ST_IDLE));

  p_srst_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (state_o == ST_IDLE));

  p_start_active_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == ST_IDLE && run_bit && !soft_rst) |=> (state_o == ST_ACTIVE));

  p_drain_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == ST_ACTIVE && xfer_last && run_bit && !soft_rst) |=> (state_o == ST_DRAIN));

  p_done_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == ST_DONE && drv_irq) |-> host_irq_o);

endmodule

// File: rtl/ide_bm_cfg_regs.sv
module ide_bm_cfg_regs
  import ide_bm_pkg::*;
#(
  parameter int unsigned NCH        = 2,
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned CMD_BASE   = CMD_BASE_DEF,
  parameter int unsigned CMD_STRIDE = CMD_STRIDE_DEF,
  parameter int unsigned CTRL_ADDR  = CTRL_ADDR_DEF,
  parameter int unsigned DIAG_ADDR  = DIAG_ADDR_DEF
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [NCH-1:0]    drv_irq,
  input  logic [NCH-1:0]    ata_rst,
  output logic [NCH-1:0]    run_bits,
  output logic              soft_rst
);

  function automatic logic [DATA_W-1:0] ctrl_wmask();
    logic [DATA_W-1:0] m;
    m = '0;
    for (int i = 0; i < NCH; i++) begin
      m[PORT_STRIDE*i]            = 1'b1;
      m[PORT_STRIDE*i + WIDE_OFS] = 1'b1;
    end
    m[LEGACY_BIT] = 1'b1;
    return m;
  endfunction

  localparam logic [DATA_W-1:0] CTRL_WMASK = ctrl_wmask();
  localparam logic [ADDR_W-1:0] CTRL_A     = ADDR_W'(CTRL_ADDR);
  localparam logic [ADDR_W-1:0] DIAG_A     = ADDR_W'(DIAG_ADDR);

  logic [DATA_W-1:0] ctrl_q, ctrl_d;
  logic [NCH-1:0]    run_q;
  logic              srst_q;
  logic              ctrl_hit, diag_hit;

  assign ctrl_hit = reg_wr && (reg_addr == CTRL_A);
  assign diag_hit = reg_wr && (reg_addr == DIAG_A);

  // control register: write, then per-port ATA reset drops the wide-mode bit
  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_hit) ctrl_d = reg_wdata & CTRL_WMASK;
    for (int i = 0; i < NCH; i++) begin
      if (ata_rst[i]) ctrl_d[PORT_STRIDE*i + WIDE_OFS] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      srst_q <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      if (diag_hit) srst_q <= reg_wdata[SRST_BIT];
    end
  end

  generate
    for (genvar g = 0; g < NCH; g++) begin : g_cmd
      localparam logic [ADDR_W-1:0] CMD_A = ADDR_W'(CMD_BASE + CMD_STRIDE*g);
      always_ff @(posedge clk) begin
        if (!rst_n)                           run_q[g] <= 1'b0;
        else if (reg_wr && reg_addr == CMD_A) run_q[g] <= reg_wdata[0];
      end

      p_atarst_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ata_rst[g] |=> !ctrl_q[PORT_STRIDE*g + WIDE_OFS]);
    end
  endgenerate

  // read-back
  always_comb begin
    reg_rdata = '0;
    if (reg_addr == CTRL_A) begin
      reg_rdata = ctrl_q;
      for (int i = 0; i < NCH; i++) reg_rdata[RAWIRQ_BASE + RAWIRQ_STEP*i] = drv_irq[i];
    end else if (reg_addr == DIAG_A) begin
      reg_rdata[SRST_BIT] = srst_q;
    end else begin
      for (int i = 0; i < NCH; i++) begin
        if (reg_addr == ADDR_W'(CMD_BASE + CMD_STRIDE*i)) reg_rdata[0] = run_q[i];
      end
    end
  end

  assign run_bits = run_q;
  assign soft_rst = srst_q;

  p_srst_keeps_ctrl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (srst_q && !ctrl_hit && ata_rst == '0) |=> $stable(ctrl_q));

  p_ctrl_ro_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_hit |=> ((ctrl_q & ~CTRL_WMASK) == '0));

endmodule

// File: rtl/ide_bm_ctl.sv
module ide_bm_ctl
  import ide_bm_pkg::*;
#(
  parameter int unsigned NCH        = 2,
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned CMD_BASE   = CMD_BASE_DEF,
  parameter int unsigned CMD_STRIDE = CMD_STRIDE_DEF,
  parameter int unsigned CTRL_ADDR  = CTRL_ADDR_DEF,
  parameter int unsigned DIAG_ADDR  = DIAG_ADDR_DEF
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [NCH-1:0]    drv_irq,
  input  logic [NCH-1:0]    xfer_last,
  input  logic [NCH-1:0]    drain_empty,
  input  logic [NCH-1:0]    ata_rst,
  output logic [NCH-1:0]    host_irq,
  output logic [2*NCH-1:0]  chan_state
);

  logic [NCH-1:0] run_bits;
  logic           soft_rst;

  ide_bm_cfg_regs #(
    .NCH(NCH), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .CMD_BASE(CMD_BASE), .CMD_STRIDE(CMD_STRIDE),
    .CTRL_ADDR(CTRL_ADDR), .DIAG_ADDR(DIAG_ADDR)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .drv_irq(drv_irq), .ata_rst(ata_rst),
    .run_bits(run_bits), .soft_rst(soft_rst)
  );

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_chan
      ide_bm_chan_fsm u_fsm (
        .clk(clk), .rst_n(rst_n),
        .run_bit(run_bits[c]), .soft_rst(soft_rst),
        .xfer_last(xfer_last[c]), .drain_empty(drain_empty[c]),
        .drv_irq(drv_irq[c]),
        .state_o(chan_state[2*c +: 2]),
        .host_irq_o(host_irq[c])
      );
    end
  endgenerate

endmodule

// File: tb/tb_ide_bm_ctl.sv
module tb_ide_bm_ctl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [1:0]  drv_irq = '0, xfer_last = '0, drain_empty = '0, ata_rst = '0;
  logic [1:0]  host_irq;
  logic [3:0]  chan_state;

  int total = 0;
  int bad   = 0;
  bit ended = 1'b0;

  always #2 clk = ~clk;

  ide_bm_ctl dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .drv_irq(drv_irq),
    .xfer_last(xfer_last), .drain_empty(drain_empty), .ata_rst(ata_rst),
    .host_irq(host_irq), .chan_state(chan_state)
  );

  // {write value, expected read-back} with drive interrupts low
  localparam logic [63:0] VEC [8] = '{
    {32'hFFFF_FFFF, 32'h0000_0833},
    {32'h0000_0000, 32'h0000_0000},
    {32'h0000_0001, 32'h0000_0001},
    {32'h0000_0820, 32'h0000_0820},
    {32'h5000_0000, 32'h0000_0000},
    {32'h0000_F0F3, 32'h0000_0033},
    {32'h0000_0800, 32'h0000_0800},
    {32'h0000_0012, 32'h0000_0012}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #0.5;
    d = reg_rdata;
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    // R1 reset state
    rd(8'h40, v); chk("R1 ctrl after reset", v, 32'h0);
    chk("R1 states idle", {28'h0, chan_state}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R8 table walk
    for (int k = 0; k < 8; k++) begin
      wr(8'h40, VEC[k][63:32]);
      rd(8'h40, v);
      chk($sformatf("R8 ctrl pattern %0d", k), v, VEC[k][31:0]);
    end
    wr(8'h40, 32'h0);

    // R1/R5/R7 idle: interrupts pass, raw bits visible
    drv_irq = 2'b11; #0.5;
    chk("R5 idle passthrough", {30'h0, host_irq}, 32'h3);
    rd(8'h40, v); chk("R7 raw irq both", v, 32'h5000_0000);

    // R2 start channel 0
    wr(8'h00, 32'h1);
    rd(8'h00, v); chk("R12 cmd readback", v, 32'h1);
    chk("R2 still idle right after write", {30'h0, chan_state[1:0]}, 32'h0);
    @(negedge clk); #0.5;
    chk("R2 active", {30'h0, chan_state[1:0]}, 32'h1);
    chk("R5 holdoff ch0 only", {30'h0, host_irq}, 32'h2);
    rd(8'h40, v); chk("R7 raw irq under holdoff", v, 32'h5000_0000);

    // R3 active -> drain
    xfer_last = 2'b01;
    @(negedge clk); xfer_last = 2'b00; #0.5;
    chk("R3 drain", {30'h0, chan_state[1:0]}, 32'h2);
    chk("R5 holdoff in drain", {31'h0, host_irq[0]}, 32'h0);

    // R6 drain -> done releases irq in same cycle
    drain_empty = 2'b01;
    @(negedge clk); drain_empty = 2'b00; #0.5;
    chk("R3 done", {30'h0, chan_state[1:0]}, 32'h3);
    chk("R6 release on done", {31'h0, host_irq[0]}, 32'h1);
    @(negedge clk); #0.5;
    chk("R3 done holds", {30'h0, chan_state[1:0]}, 32'h3);

    // R4 stop from done
    wr(8'h00, 32'h0);
    @(negedge clk); #0.5;
    chk("R4 stop from done", {30'h0, chan_state[1:0]}, 32'h0);

    // R4 stop from active on channel 1
    wr(8'h08, 32'h1);
    @(negedge clk); #0.5;
    chk("R2 ch1 active", {30'h0, chan_state[3:2]}, 32'h1);
    chk("R5 holdoff ch1 only", {30'h0, host_irq}, 32'h1);
    wr(8'h08, 32'h0);
    @(negedge clk); #0.5;
    chk("R4 stop from active", {30'h0, chan_state[3:2]}, 32'h0);

    // R9 / R10 soft reset
    wr(8'h40, 32'h0000_0833);
    wr(8'h00, 32'h1);
    @(negedge clk); #0.5;
    chk("R9 pre active", {30'h0, chan_state[1:0]}, 32'h1);
    wr(8'h7C, 32'h0004_0000);
    rd(8'h7C, v); chk("R9 srst readback", v, 32'h0004_0000);
    @(negedge clk); #0.5;
    chk("R9 forced idle", {30'h0, chan_state[1:0]}, 32'h0);
    repeat (2) @(negedge clk); #0.5;
    chk("R9 held idle with start set", {30'h0, chan_state[1:0]}, 32'h0);
    rd(8'h40, v); chk("R10 ctrl untouched by srst", v, 32'h5000_0833);
    wr(8'h7C, 32'h0);
    @(negedge clk); #0.5;
    chk("R9 rearm after release", {30'h0, chan_state[1:0]}, 32'h1);
    wr(8'h00, 32'h0);

    // R11 ATA reset
    @(negedge clk);
    ata_rst = 2'b01;
    @(negedge clk); ata_rst = 2'b00;
    rd(8'h40, v); chk("R11 port0 wide cleared", v, 32'h5000_0831);
    reg_wr = 1'b1; reg_addr = 8'h40; reg_wdata = 32'h0000_0833; ata_rst = 2'b10;
    @(negedge clk); reg_wr = 1'b0; ata_rst = 2'b00;
    rd(8'h40, v); chk("R11 ata reset beats write", v, 32'h5000_0813);

    // R1 mid-run reset
    wr(8'h08, 32'h1);
    rst_n = 1'b0;
    @(negedge clk);
    rd(8'h40, v); chk("R1 ctrl cleared", v, 32'h5000_0000);
    rd(8'h08, v); chk("R1 cmd cleared", v, 32'h0);
    chk("R1 states idle again", {28'h0, chan_state}, 32'h0);
    chk("R1 irq follows drive", {30'h0, host_irq}, 32'h3);
    rst_n = 1'b1;
    drv_irq = 2'b00;
    @(negedge clk);
    finish_run();
  end

endmodule